// File: doc/BRIEF.md
# UART Interrupt Source Generator

This block derives the interrupt lines of a serial port from occupancy and event strobes. It never sees the data itself. The transmit and receive paths report each byte entering or leaving their queues through single-cycle strobes. The block keeps its own count of how many bytes each queue holds.

From these counts, from the flow-control input lines and from a bit-period tick, it builds four interrupt sources:
- transmit space available;
- receive data available;
- flow-control line change;
- receive idle timeout.

Each source has its own mask bit. The block drives a transmit line, a receive line and a combined line to an external interrupt controller. A small register port holds the control bits (port enable, queue mode) and the masks. The same port exposes the raw and masked source state and the synchronized flow-control lines.

The queue mode sets how the sources behave. In deep mode each queue holds `DEPTH` bytes, and the transmit and receive sources switch at half that depth. In single-register mode each direction holds one byte, and the sources follow empty or full. Clearing the port enable stalls both directions together.

Top module: `uart_irq_gen`

## Requirements
- R1: After reset the control register (address 0) and the mask register (address 1) read 0, and all three interrupt outputs are low. The raw status register (address 2) reads 0x01: the transmit source is active because the single holding register is empty.
- R2: In deep mode (control bit 1 = 1), raw transmit (status bit 0) is 1 exactly when the port is enabled (control bit 0 = 1) and the transmit count is below `DEPTH`/2. With `DEPTH` = 16 it reads 1 at count 7 and 0 at count 8.
- R3: In single-register mode (control bit 1 = 0), raw transmit is 1 exactly when the holding register is empty, whatever the enable bit. A `tx_push` fills the register and clears the source.
- R4: In deep mode, raw receive (status bit 1) is 1 exactly when the receive count is at least `DEPTH`/2. It drops as soon as a read brings the count below that.
- R5: In single-register mode, raw receive is 1 while one byte is held and returns to 0 when that byte is read with `rx_pop`.
- R6: Raw timeout (status bit 3) sets once `TIMEOUT_BITS` `bit_tick` pulses have arrived while the receive queue is non-empty and with no `rx_push` or `rx_pop` since. Any such strobe restarts the count. Once set, the source stays set until the receive queue is empty.
- R7: Raw modem status (status bit 2) sets when any synchronized `modem_in` line changes level. It clears when address 4 is written. Reading address 4 returns the synchronized lines in its low bits.
- R8: Mask register bits 0..3 gate sources tx, rx, modem and timeout. `irq_tx` and `irq_rx` are the masked transmit and receive sources. The pending register (address 3) shows the masked sources in bits 0..3 and the combined line in bit 4. Raw status stays readable when a source is masked.
- R9: `irq_any` is high exactly when at least one masked source is active.
- R10: While control bit 0 is 0, `rx_push` and `tx_pop` are ignored and `rx_run` and `tx_run` are low. `tx_run` is high only when the port is enabled and transmit data is queued.
- R11: A push into a full queue and a pop from an empty queue are ignored. Capacity is `DEPTH` in deep mode and 1 in single-register mode.
- R12: A control write that changes the mode bit empties both queue counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Byte written into the transmit queue |
| tx_pop | input | 1 | Serializer took a byte from the transmit queue |
| rx_push | input | 1 | Deserializer delivered a byte into the receive queue |
| rx_pop | input | 1 | Byte read out of the receive queue |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| modem_in | input | MODEM_W | Flow-control input lines (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on address) |
| tx_run | output | 1 | Transmit side may pull a byte |
| rx_run | output | 1 | Receive side may deliver bytes |
| irq_tx | output | 1 | Masked transmit interrupt |
| irq_rx | output | 1 | Masked receive interrupt |
| irq_any | output | 1 | Combined interrupt |

## Verification
The bench targets the exact half-depth thresholds. It walks both queues across 7, 8 and back, in both directions. An off-by-one comparison would move an edge by one byte.

It fills the transmit queue past capacity, then counts the pops needed to cross half again. A design that let the count wrap or grow past `DEPTH` would need the wrong number of pops.

The idle timer is checked at tick 31 and tick 32, and again after a mid-window restart. The bench also drains the receive queue in stages to confirm that the timeout source stays set until the queue is empty. A non-sticky design, or a timer that does not restart on a new byte, fails these checks.

Enable-gating is tested in both modes, because only the deep-mode transmit source depends on it. The mode-switch flush is tested as well. A design that kept stale counts across a mode change would show a raw receive bit that is still set.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   localparam int ADDR_W = 3;
   localparam int SRC_N  = 4;

   // source bit positions, shared by mask, raw and pending views
   localparam int SRC_TX = 0;
   localparam int SRC_RX = 1;
   localparam int SRC_MS = 2;
   localparam int SRC_RT = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL  = 3'd0,
      RA_MASK  = 3'd1,
      RA_RAW   = 3'd2,
      RA_PEND  = 3'd3,
      RA_MODEM = 3'd4
   } reg_addr_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_DEEP_BIT = 1;

endpackage

// File: rtl/uirq_level_trk.sv
// Occupancy counter for one queue; capacity switches between DEPTH and 1.
module uirq_level_trk #(
   parameter int DEPTH = 16,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             deep,
   input  logic             push,
   input  logic             pop,
   output logic [LVL_W-1:0] level
);

   localparam logic [LVL_W-1:0] CAP_DEEP = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] CAP_ONE  = LVL_W'(1);

   logic [LVL_W-1:0] cap;
   logic             do_push;
   logic             do_pop;

   assign cap     = deep ? CAP_DEEP : CAP_ONE;
   assign do_push = push && (level < cap);
   assign do_pop  = pop && (level != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= '0;
      end else if (flush) begin
         level <= '0;
      end else if (do_push && !do_pop) begin
         level <= level + LVL_W'(1);
      end else if (do_pop && !do_push) begin
         level <= level - LVL_W'(1);
      end
   end

endmodule

// File: rtl/uirq_rx_idle.sv
// Counts bit periods of receive inactivity; sticky flag until drained.
module uirq_rx_idle #(
   parameter int LIMIT = 32,
   parameter int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic empty,
   output logic flag
);

   localparam logic [CNT_W-1:0] LIM_L  = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else if (empty) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else if (restart) begin
         cnt  <= '0;
      end else if (tick && (cnt != LIM_L)) begin
         cnt <= cnt + CNT_W'(1);
         if (cnt == LIM_M1) begin
            flag <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/uirq_msr_watch.sv
// Synchronizes flow-control lines and latches any level change.
module uirq_msr_watch #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lines_in,
   input  logic         clr,
   output logic [W-1:0] lines_sync,
   output logic         flag
);

   logic [W-1:0] prev;

   generate
      if (STAGES == 0) begin : g_direct
         assign lines_sync = lines_in;
      end else begin : g_sync
         logic [W-1:0] chain [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) begin
                  chain[s] <= '0;
               end
            end else begin
               chain[0] <= lines_in;
               for (int s = 1; s < STAGES; s++) begin
                  chain[s] <= chain[s-1];
               end
            end
         end
         assign lines_sync = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= '0;
         flag <= 1'b0;
      end else begin
         prev <= lines_sync;
         if (lines_sync != prev) begin
            flag <= 1'b1;
         end else if (clr) begin
            flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
   import uirq_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int TIMEOUT_BITS = 32,
   parameter int MODEM_W      = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int DATA_W       = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_push,
   input  logic               tx_pop,
   input  logic               rx_push,
   input  logic               rx_pop,
   input  logic               bit_tick,
   input  logic [MODEM_W-1:0] modem_in,
   input  logic               reg_wr,
   input  logic [2:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               tx_run,
   output logic               rx_run,
   output logic               irq_tx,
   output logic               irq_rx,
   output logic               irq_any
);

   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);
   localparam logic [LVL_W-1:0] HALF_L = LVL_W'(DEPTH / 2);

   // elaboration-time parameter checks
   generate
      if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
         $error("DEPTH must be even and at least 2");
      end
      if (TIMEOUT_BITS < 2) begin : g_bad_timeout
         $error("TIMEOUT_BITS must be at least 2");
      end
      if (DATA_W < SRC_N + 1) begin : g_bad_data_w
         $error("DATA_W too narrow for the pending register");
      end
      if (MODEM_W < 1 || MODEM_W > DATA_W) begin : g_bad_modem_w
         $error("MODEM_W must lie between 1 and DATA_W");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic               uart_en;
   logic               fifo_en;
   logic [SRC_N-1:0]   mask;
   logic [LVL_W-1:0]   tx_level;
   logic [LVL_W-1:0]   rx_level;
   logic               rt_flag;
   logic               ms_flag;
   logic               ms_clr;
   logic               mode_flush;
   logic [MODEM_W-1:0] modem_sync;
   logic [SRC_N-1:0]   raw;
   logic [SRC_N-1:0]   pend;
   logic               wr_ctrl;
   logic               wr_mask;
   logic               unused_wdata_hi;

   assign wr_ctrl    = reg_wr && (reg_addr == RA_CTRL);
   assign wr_mask    = reg_wr && (reg_addr == RA_MASK);
   assign ms_clr     = reg_wr && (reg_addr == RA_MODEM);
   assign mode_flush = wr_ctrl && (reg_wdata[CTRL_DEEP_BIT] != fifo_en);
   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:SRC_N];

   // control and mask registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uart_en <= 1'b0;
         fifo_en <= 1'b0;
         mask    <= '0;
      end else begin
         if (wr_ctrl) begin
            uart_en <= reg_wdata[CTRL_EN_BIT];
            fifo_en <= reg_wdata[CTRL_DEEP_BIT];
         end
         if (wr_mask) begin
            mask <= reg_wdata[SRC_N-1:0];
         end
      end
   end

   // queue occupancy; the line-side strobes stall while disabled
   uirq_level_trk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) tx_trk_i (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (mode_flush),
      .deep  (fifo_en),
      .push  (tx_push),
      .pop   (tx_pop && uart_en),
      .level (tx_level)
   );

   uirq_level_trk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) rx_trk_i (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (mode_flush),
      .deep  (fifo_en),
      .push  (rx_push && uart_en),
      .pop   (rx_pop),
      .level (rx_level)
   );

   uirq_rx_idle #(.LIMIT(TIMEOUT_BITS), .CNT_W(CNT_W)) idle_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (bit_tick),
      .restart ((rx_push && uart_en) || rx_pop),
      .empty   (rx_level == '0),
      .flag    (rt_flag)
   );

   uirq_msr_watch #(.W(MODEM_W), .STAGES(SYNC_STAGES)) msr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .lines_in   (modem_in),
      .clr        (ms_clr),
      .lines_sync (modem_sync),
      .flag       (ms_flag)
   );

   // source conditions depend on the queue mode
   always_comb begin
      if (fifo_en) begin
         raw[SRC_TX] = uart_en && (tx_level < HALF_L);
         raw[SRC_RX] = (rx_level >= HALF_L);
      end else begin
         raw[SRC_TX] = (tx_level == '0);
         raw[SRC_RX] = (rx_level != '0);
      end
      raw[SRC_MS] = ms_flag;
      raw[SRC_RT] = rt_flag;
   end

   generate
      for (genvar i = 0; i < SRC_N; i++) begin : g_gate
         assign pend[i] = raw[i] & mask[i];
      end
   endgenerate

   assign irq_tx  = pend[SRC_TX];
   assign irq_rx  = pend[SRC_RX];
   assign irq_any = |pend;
   assign rx_run  = uart_en;
   assign tx_run  = uart_en && (tx_level != '0);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CTRL_EN_BIT]   = uart_en;
            reg_rdata[CTRL_DEEP_BIT] = fifo_en;
         end
         RA_MASK:  reg_rdata[SRC_N-1:0] = mask;
         RA_RAW:   reg_rdata[SRC_N-1:0] = raw;
         RA_PEND:  reg_rdata[SRC_N:0]   = {irq_any, pend};
         RA_MODEM: reg_rdata[MODEM_W-1:0] = modem_sync;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
   parameter int DEPTH = 16,
   parameter int LVL_W = $clog2(DEPTH + 1),
   parameter int MODEM_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               uart_en,
   input logic               fifo_en,
   input logic [3:0]         mask,
   input logic [LVL_W-1:0]   tx_level,
   input logic [LVL_W-1:0]   rx_level,
   input logic               rt_flag,
   input logic               ms_flag,
   input logic               ms_clr,
   input logic [MODEM_W-1:0] modem_sync,
   input logic               irq_tx,
   input logic               irq_any
);

   AST_TX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tx_level) <= (fifo_en ? DEPTH : 1));                          // R11
   AST_RX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rx_level) <= (fifo_en ? DEPTH : 1));                          // R11
   AST_RT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |=> !rt_flag);                                    // R6
   AST_MS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_clr && $stable(modem_sync)) |=> !ms_flag);                     // R7
   AST_DIS_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
      !uart_en |=> (rx_level <= $past(rx_level)));                       // R10
   AST_ANY_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any |-> (mask != 4'b0000));                                    // R9
   AST_HOLD_TX_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && tx_level == '0 && mask[0]) |-> irq_tx);               // R3

endmodule

bind uart_irq_gen uirq_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W), .MODEM_W(MODEM_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .uart_en    (uart_en),
   .fifo_en    (fifo_en),
   .mask       (mask),
   .tx_level   (tx_level),
   .rx_level   (rx_level),
   .rt_flag    (rt_flag),
   .ms_flag    (ms_flag),
   .ms_clr     (ms_clr),
   .modem_sync (modem_sync),
   .irq_tx     (irq_tx),
   .irq_any    (irq_any)
);

// File: tb/uart_irq_gen_tb_top.sv
module uart_irq_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, bit_tick = 0;
   logic [3:0] modem_in = '0;
   logic       reg_wr = 0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       tx_run, rx_run, irq_tx, irq_rx, irq_any;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   uart_irq_gen dut_i (
      .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_pop(rx_pop), .bit_tick(bit_tick),
      .modem_in(modem_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_run(tx_run),
      .rx_run(rx_run), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_any(irq_any)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic push_tx(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tx_push = 1;
         @(negedge clk) tx_push = 0;
      end
   endtask

   task automatic pop_tx(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tx_pop = 1;
         @(negedge clk) tx_pop = 0;
      end
   endtask

   task automatic push_rx(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) rx_push = 1;
         @(negedge clk) rx_push = 0;
      end
   endtask

   task automatic pop_rx(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) rx_pop = 1;
         @(negedge clk) rx_pop = 0;
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) bit_tick = 1;
         @(negedge clk) bit_tick = 0;
      end
   endtask

   task automatic settle();
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(3'd0, v); check("R1 ctrl", v, 0);
      rd(3'd1, v); check("R1 mask", v, 0);
      rd(3'd2, v); check("R1 raw", v, 8'h01);
      check("R1 irqs", {irq_tx, irq_rx, irq_any}, 0);
   endtask

   task automatic t_hold_tx();
      logic [7:0] v;
      wr(3'd1, 8'h0F);
      rd(3'd1, v); check("R8 mask readback", v, 8'h0F);
      check("R3 empty holding irq while disabled", irq_tx, 1);
      rd(3'd3, v); check("R8 pending view", v, 8'h11);
      push_tx(1);
      check("R3 write clears tx", irq_tx, 0);
      push_tx(1);
      pop_tx(1);
      check("R10 pop ignored while disabled", irq_tx, 0);
      check("R10 tx_run low while disabled", tx_run, 0);
      wr(3'd0, 8'h01);
      check("R10 tx_run with data queued", tx_run, 1);
      pop_tx(1);
      check("R11 holding held one byte only", irq_tx, 1);
   endtask

   task automatic t_rx_hold();
      logic [7:0] v;
      push_rx(1);
      check("R5 byte held", irq_rx, 1);
      push_rx(1);
      pop_rx(1);
      rd(3'd2, v); check("R5 cleared by read, R11 overflow dropped", v[1], 0);
      pop_rx(1);
      wr(3'd0, 8'h00);
      check("R10 rx_run low", rx_run, 0);
      push_rx(1);
      check("R10 rx push ignored while disabled", irq_rx, 0);
   endtask

   task automatic t_fifo_tx();
      logic [7:0] v;
      wr(3'd0, 8'h03);
      check("R12 flush on mode change", irq_tx, 1);
      push_tx(7);
      check("R2 level 7 below half", irq_tx, 1);
      push_tx(1);
      check("R2 level 8 not below half", irq_tx, 0);
      pop_tx(1);
      check("R2 back to 7", irq_tx, 1);
      wr(3'd0, 8'h02);
      check("R2 gated by enable", irq_tx, 0);
      wr(3'd0, 8'h03);
      push_tx(11);
      pop_tx(8);
      check("R11 capacity 16: level 8", irq_tx, 0);
      pop_tx(1);
      check("R11 capacity 16: level 7", irq_tx, 1);
      rd(3'd2, v); check("R2 raw tx bit", v[0], 1);
   endtask

   task automatic t_rx_fifo();
      push_rx(7);
      check("R4 level 7", irq_rx, 0);
      push_rx(1);
      check("R4 level 8", irq_rx, 1);
      pop_rx(1);
      check("R4 read below half", irq_rx, 0);
      push_rx(1);
      check("R4 refill to half", irq_rx, 1);
      pop_rx(8);
      check("R4 drained", irq_rx, 0);
   endtask

   task automatic t_timeout();
      logic [7:0] v;
      push_rx(2);
      ticks(31);
      rd(3'd2, v); check("R6 not yet at 31", v[3], 0);
      ticks(1);
      rd(3'd2, v); check("R6 set at 32", v[3], 1);
      check("R9 combined from timeout", irq_any, 1);
      push_rx(1);
      pop_rx(2);
      rd(3'd2, v); check("R6 sticky until drained", v[3], 1);
      pop_rx(1);
      settle();
      rd(3'd2, v); check("R6 cleared when empty", v[3], 0);
      push_rx(1);
      ticks(20);
      push_rx(1);
      ticks(20);
      rd(3'd2, v); check("R6 restart on new byte", v[3], 0);
      ticks(12);
      rd(3'd2, v); check("R6 fires after restart", v[3], 1);
      pop_rx(2);
      settle();
   endtask

   task automatic t_modem();
      logic [7:0] v;
      rd(3'd2, v); check("R7 idle", v[2], 0);
      @(negedge clk) modem_in = 4'b0001;
      repeat (5) @(negedge clk);
      rd(3'd2, v); check("R7 change detected", v[2], 1);
      rd(3'd4, v); check("R7 synced lines", v, 8'h01);
      wr(3'd4, 8'h00);
      rd(3'd2, v); check("R7 cleared by write", v[2], 0);
      @(negedge clk) modem_in = 4'b0000;
      repeat (5) @(negedge clk);
      rd(3'd2, v); check("R7 falling change", v[2], 1);
      wr(3'd4, 8'h00);
   endtask

   task automatic t_combined();
      logic [7:0] v;
      wr(3'd1, 8'h02);
      check("R8 tx masked", irq_tx, 0);
      check("R9 nothing pending", irq_any, 0);
      rd(3'd2, v); check("R8 raw visible while masked", v[0], 1);
      push_rx(8);
      check("R9 combined from rx", irq_any, 1);
      rd(3'd3, v); check("R8 pending rx", v, 8'h12);
      wr(3'd0, 8'h01);
      rd(3'd2, v); check("R12 rx count flushed", v[1], 0);
      wr(3'd1, 8'h00);
      check("R9 all masked", irq_any, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hold_tx();
      t_rx_hold();
      t_fifo_tx();
      t_rx_fifo();
      t_timeout();
      t_modem();
      t_combined();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule